// File: doc/BRIEF.md
# Block-Move DMA Controller

This controller copies a run of words between one peripheral and system memory so that the processor does not have to move each word itself. Software reaches it through four word-wide registers on a small synchronous register bus. It loads a first memory address, a word count, and a control word that carries the direction and an interrupt enable. It then writes a separate command register to launch the run. The addresses the controller drives are used by memory as they are. No translation is applied.

While a run is active the engine runs two handshakes, one after the other, for each word. Toward the peripheral it raises a request and waits for an acknowledge. Toward memory it raises a request, with a write strobe and an address, and waits for a ready. After each word the address steps up by one and the remaining count steps down by one. When the count reaches zero, busy drops and done rises. A level interrupt stays high while done and the enable bit are both set. Software reads busy, done and error from the command/status register and clears them by writing that register.

Top module: `dma_engine`

## Requirements
- R1: While idle, register writes load the setup state. Register 0 holds the memory address and register 1 holds the word count, both read back zero-extended. Register 2 holds the direction in bit 0 (0 = peripheral to memory, 1 = memory to peripheral) and the interrupt enable in bit 1. After reset all of these read 0.
- R2: A write to register 3 with bit 0 set launches a run when idle and the count is nonzero. Busy (bit 0 when register 3 is read) is high from the next cycle. In that same cycle the first request is raised: `dev_req` for direction 0, `mem_req` for direction 1.
- R3: In direction 0, each word is taken from `dev_rdata` in the cycle where `dev_req` and `dev_ack` are both high. It is then written to memory: `mem_req` is held with `mem_we`=1 and `mem_wdata` equal to that word until `mem_rdy`.
- R4: In direction 1, each word is read from memory with `mem_we`=0 and captured when `mem_rdy` is high. It is then offered on `dev_wdata` with `dev_req` held until `dev_ack`.
- R5: `mem_addr` equals the address register. When a word's final handshake completes, the address register increments by one and the count register decrements by one.
- R6: When the last word completes, busy clears and done (bit 1 when register 3 is read) sets, on the same edge.
- R7: Done and error stay set until software writes register 3 with bit 1 set, which clears both.
- R8: A launch issued while the count is zero sets error (bit 2 when register 3 is read), leaves busy low and raises no request.
- R9: While busy, writes to registers 0, 1 and 2 and further launch commands are ignored.
- R10: `irq` is high exactly while done and the interrupt enable are both set.
- R11: `dev_req` and `mem_req` are never high together, and each request stays high until its handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| dev_req | output | 1 | Request to peripheral |
| dev_ack | input | 1 | Peripheral acknowledge |
| dev_rdata | input | DW | Word from peripheral |
| dev_wdata | output | DW | Word to peripheral |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdy | input | 1 | Memory ready |
| mem_rdata | input | DW | Memory read data |
| irq | output | 1 | Level completion interrupt |

## Verification
A register write takes effect on the edge after the write strobe is sampled. A launch shows busy and the first request in the very next cycle. Each handshake completing on an edge moves the request to the other side, or drops it, by that same edge. Done, busy and the interrupt change on the edge that completes the last word. The bench drives inputs just after each rising edge. It keeps a behavioural model that updates on the same edges from the same inputs and compares every output at the falling edge, so each result is checked in the exact cycle it is due. End-of-run checks compare memory contents and received peripheral words against values computed from the transfer setup.

// File: rtl/dma_pkg.sv
// Shared types and register select codes for the block-move DMA controller.
package dma_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DEV  = 2'd1,
        PH_MEM  = 2'd2
    } phase_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_CMD  = 2'd3;

    localparam int CMD_GO_BIT    = 0;
    localparam int CMD_CLEAR_BIT = 1;
    localparam int CTRL_DIR_BIT  = 0;
    localparam int CTRL_IE_BIT   = 1;
endpackage

// File: rtl/dma_csr.sv
// Register file and run bookkeeping for the DMA controller.
// Holds the live address/count (loaded by software, stepped per word),
// direction, interrupt enable and busy/done/error flags.
// Assumes DW >= AW, DW >= CW and DW >= 3.
module dma_csr #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          word_done,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_len,
    output logic          dir,
    output logic          ie,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          launch,
    output logic          last_word
);
    import dma_pkg::*;

    logic cmd_hit, go_req, clr_req, zero_go, setup_ok, finish;
    logic unused_wdata_bits;

    assign cmd_hit   = reg_wr && (reg_addr == SEL_CMD);
    assign go_req    = cmd_hit && reg_wdata[CMD_GO_BIT] && !busy;
    assign clr_req   = cmd_hit && reg_wdata[CMD_CLEAR_BIT];
    assign launch    = go_req && (cur_len != '0);
    assign zero_go   = go_req && (cur_len == '0);
    assign setup_ok  = reg_wr && !busy;
    assign last_word = (cur_len == CW'(1));
    assign finish    = word_done && last_word;
    assign unused_wdata_bits = ^reg_wdata;

    // Address register: software load while idle, step after each word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (setup_ok && reg_addr == SEL_ADDR)
            cur_addr <= reg_wdata[AW-1:0];
        else if (word_done)
            cur_addr <= cur_addr + AW'(1);
    end

    // Count register: software load while idle, count down per word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_len <= '0;
        else if (setup_ok && reg_addr == SEL_LEN)
            cur_len <= reg_wdata[CW-1:0];
        else if (word_done)
            cur_len <= cur_len - CW'(1);
    end

    // Control bits: direction and interrupt enable, locked while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= 1'b0;
            ie  <= 1'b0;
        end else if (setup_ok && reg_addr == SEL_CTRL) begin
            dir <= reg_wdata[CTRL_DIR_BIT];
            ie  <= reg_wdata[CTRL_IE_BIT];
        end
    end

    // Status flags: busy from launch to last word, sticky done and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (launch)
                busy <= 1'b1;
            else if (finish)
                busy <= 1'b0;

            if (finish)
                done <= 1'b1;
            else if (clr_req)
                done <= 1'b0;

            if (zero_go)
                err <= 1'b1;
            else if (clr_req)
                err <= 1'b0;
        end
    end

    // Read mux: zero-extended view of the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_ADDR: reg_rdata[AW-1:0] = cur_addr;
            SEL_LEN:  reg_rdata[CW-1:0] = cur_len;
            SEL_CTRL: begin
                reg_rdata[CTRL_DIR_BIT] = dir;
                reg_rdata[CTRL_IE_BIT]  = ie;
            end
            default:  reg_rdata[2:0] = {err, done, busy};
        endcase
    end
endmodule

// File: rtl/dma_mover.sv
// Word mover for the DMA controller: sequences the peripheral and memory
// handshakes for each word and holds the word in flight.
// Direction 0 takes the peripheral side first, direction 1 the memory side.
// Assumes dir is stable while a run is active.
module dma_mover #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          dir,
    input  logic          last_word,
    output logic          dev_req,
    input  logic          dev_ack,
    input  logic [DW-1:0] dev_rdata,
    output logic          mem_req,
    output logic          mem_we,
    input  logic          mem_rdy,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] hold_word,
    output logic          word_done
);
    import dma_pkg::*;

    phase_t phase, phase_nx;
    logic   dev_fire, mem_fire;

    assign dev_req   = (phase == PH_DEV);
    assign mem_req   = (phase == PH_MEM);
    assign mem_we    = mem_req && !dir;
    assign dev_fire  = dev_req && dev_ack;
    assign mem_fire  = mem_req && mem_rdy;
    assign word_done = (dev_fire && dir) || (mem_fire && !dir);

    // Next phase: alternate sides per word, return to idle after the last.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (launch) phase_nx = dir ? PH_MEM : PH_DEV;
            PH_DEV:  if (dev_ack) phase_nx = (dir && last_word) ? PH_IDLE : PH_MEM;
            PH_MEM:  if (mem_rdy) phase_nx = (!dir && last_word) ? PH_IDLE : PH_DEV;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else
            phase <= phase_nx;
    end

    // Word buffer: captures from whichever side supplies the data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_word <= '0;
        else if (dev_fire && !dir)
            hold_word <= dev_rdata;
        else if (mem_fire && dir)
            hold_word <= mem_rdata;
    end
endmodule

// File: rtl/dma_engine.sv
// Top of the block-move DMA controller. Joins the register file with the
// word mover and forms the level interrupt.
// Assumes a single synchronous clock and physical word addresses.
module dma_engine #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          dev_req,
    input  logic          dev_ack,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] dev_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rdy,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq
);
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_len;
    logic          dir, ie, busy, done, err, launch, last_word, word_done;
    logic [DW-1:0] hold_word;

    dma_csr #(.AW(AW), .CW(CW), .DW(DW)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_done(word_done),
        .cur_addr(cur_addr), .cur_len(cur_len), .dir(dir), .ie(ie),
        .busy(busy), .done(done), .err(err), .launch(launch),
        .last_word(last_word)
    );

    dma_mover #(.DW(DW)) u_mover (
        .clk(clk), .rst_n(rst_n), .launch(launch), .dir(dir),
        .last_word(last_word), .dev_req(dev_req), .dev_ack(dev_ack),
        .dev_rdata(dev_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .hold_word(hold_word),
        .word_done(word_done)
    );

    assign mem_addr  = cur_addr;
    assign mem_wdata = hold_word;
    assign dev_wdata = hold_word;
    assign irq       = done && ie;
endmodule

// File: rtl/dma_engine_chk.sv
// Property checker for dma_engine, attached by bind below.
module dma_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          dev_req,
    input logic          dev_ack,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_rdy,
    input logic          busy,
    input logic          err,
    input logic [AW-1:0] cur_addr,
    input logic [CW-1:0] cur_len
);
    // R11: only one side is requested at a time
    a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_req && mem_req));

    // R11: peripheral request held until acknowledged
    a_r11_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req && !dev_ack |=> dev_req);

    // R11: memory request held until ready
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req);

    // R2: no request is raised outside a run
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dev_req && !mem_req);

    // R8: launch with zero count flags error and stays idle
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 2'd3 && reg_wdata[0] && !busy && cur_len == '0
        |=> err && !busy);

    // R5: a completed memory write steps the address by one
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rdy && mem_we |=> cur_addr == $past(cur_addr) + AW'(1));
endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_rdy(mem_rdy), .busy(busy),
    .err(err), .cur_addr(cur_addr), .cur_len(cur_len)
);

// File: tb/sim_dma_engine.sv
// Bench for dma_engine: behavioural per-cycle model plus peripheral and
// memory responders with adjustable latency.
module sim_dma_engine;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dev_req, mem_req, mem_we, irq;
    logic          dev_ack = 1'b0;
    logic          mem_rdy = 1'b0;
    logic [DW-1:0] dev_rdata = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] dev_wdata, mem_wdata;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    dma_engine #(.AW(AW), .CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    int nchk = 0;
    int nfail = 0;
    bit compare_on = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", what, act, exp, $time);
        end
    endtask

    // Peripheral and memory responders
    int dlat = 0, mlat = 0, dwait = 0, mwait = 0;
    int dev_idx = 0, got_idx = 0;
    logic [DW-1:0] mem [256];
    logic [DW-1:0] dev_got [64];

    function automatic logic [DW-1:0] src_word(input int i);
        return 32'hA000_0000 + DW'(i * 7);
    endfunction
    function automatic logic [DW-1:0] init_word(input int i);
        return 32'h5000_0000 ^ DW'(i * 13);
    endfunction

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = init_word(i);
            dev_ack = 0; mem_rdy = 0; dwait = 0; mwait = 0;
        end else begin
            if (dev_req && !dev_ack) begin
                if (dwait >= dlat) begin
                    dev_ack = 1; dev_rdata = src_word(dev_idx); dev_idx++;
                    dev_got[got_idx % 64] = dev_wdata; got_idx++;
                    dwait = 0;
                end else dwait++;
            end else dev_ack = 0;
            if (mem_req && !mem_rdy) begin
                if (mwait >= mlat) begin
                    mem_rdy = 1;
                    if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                    else mem_rdata = mem[mem_addr[7:0]];
                    mwait = 0;
                end else mwait++;
            end else mem_rdy = 0;
        end
    end

    // Behavioural reference model, stepped on each rising edge
    int m_ph;
    bit m_busy, m_done, m_err, m_dir, m_ie;
    int m_addr, m_len;
    logic [DW-1:0] m_buf;
    bit cmd, wd, lst, ob;
    int olen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_busy = 0; m_done = 0; m_err = 0; m_dir = 0; m_ie = 0;
            m_addr = 0; m_len = 0; m_buf = '0;
        end else begin
            ob = m_busy; olen = m_len;
            cmd = reg_wr && reg_addr == 2'd3;
            wd = (m_ph == 1 && dev_ack && m_dir) || (m_ph == 2 && mem_rdy && !m_dir);
            lst = wd && m_len == 1;
            if (m_ph == 1 && dev_ack && !m_dir) m_buf = dev_rdata;
            if (m_ph == 2 && mem_rdy && m_dir) m_buf = mem_rdata;
            if (m_ph == 0) begin
                if (cmd && reg_wdata[0] && olen != 0) begin m_ph = m_dir ? 2 : 1; m_busy = 1; end
            end else if (m_ph == 1) begin
                if (dev_ack) m_ph = lst ? 0 : 2;
            end else if (mem_rdy) m_ph = lst ? 0 : 1;
            if (lst) m_busy = 0;
            if (!ob && reg_wr) begin
                if (reg_addr == 2'd0) m_addr = int'(reg_wdata[15:0]);
                if (reg_addr == 2'd1) m_len = int'(reg_wdata[15:0]);
                if (reg_addr == 2'd2) begin m_dir = reg_wdata[0]; m_ie = reg_wdata[1]; end
            end
            if (wd) begin m_addr = (m_addr + 1) & 16'hffff; m_len = (m_len - 1) & 16'hffff; end
            if (lst) m_done = 1; else if (cmd && reg_wdata[1]) m_done = 0;
            if (cmd && reg_wdata[0] && !ob && olen == 0) m_err = 1;
            else if (cmd && reg_wdata[1]) m_err = 0;
        end
    end

    function automatic logic [DW-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return DW'(m_addr);
            2'd1: return DW'(m_len);
            2'd2: return DW'({m_ie, m_dir});
            default: return DW'({m_err, m_done, m_busy});
        endcase
    endfunction

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (compare_on) begin
            chk(dev_req == (m_ph == 1), "R2/R11 dev_req", dev_req, m_ph == 1);
            chk(mem_req == (m_ph == 2), "R2/R11 mem_req", mem_req, m_ph == 2);
            chk(irq == (m_done && m_ie), "R10 irq", irq, m_done && m_ie);
            chk(reg_rdata == m_read(reg_addr), "R1/R6/R7/R9 reg_rdata", reg_rdata, m_read(reg_addr));
            if (mem_req) begin
                chk(mem_we == !m_dir, "R3/R4 mem_we", mem_we, !m_dir);
                chk(int'(mem_addr) == m_addr, "R5 mem_addr", mem_addr, m_addr);
                if (!m_dir) chk(mem_wdata == m_buf, "R3 mem_wdata", mem_wdata, m_buf);
            end
            if (dev_req && m_dir) chk(dev_wdata == m_buf, "R4 dev_wdata", dev_wdata, m_buf);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_addr = 2'd3;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [DW-1:0] exp, input string what);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, what, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        reg_addr = 2'd3;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!reg_rdata[0]) break;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int base_idx;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        compare_on = 1;
        // R1 reset state
        rd_chk(2'd0, 0, "R1 reset addr");
        rd_chk(2'd3, 0, "R1 reset status");
        chk(irq == 0, "R10 reset irq", irq, 0);

        // R1 setup readback
        wr(2'd0, 32'h0000_0010);
        wr(2'd1, 32'h0000_0004);
        wr(2'd2, 32'h0000_0002);
        rd_chk(2'd0, 32'h10, "R1 addr readback");
        rd_chk(2'd1, 32'h4, "R1 len readback");
        rd_chk(2'd2, 32'h2, "R1 ctrl readback");

        // R2 R3 R6 R10: peripheral to memory, 4 words
        dlat = 0; mlat = 2;
        base_idx = dev_idx;
        wr(2'd3, 32'h1);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk(mem[8'h10 + i] == src_word(base_idx + i), "R3 memory word", mem[8'h10 + i], src_word(base_idx + i));
        rd_chk(2'd3, 32'h2, "R6 done after run");
        rd_chk(2'd0, 32'h14, "R5 final addr");
        rd_chk(2'd1, 32'h0, "R5 final len");
        chk(irq == 1, "R10 irq set", irq, 1);

        // R7 clear
        wr(2'd3, 32'h2);
        rd_chk(2'd3, 32'h0, "R7 cleared");
        chk(irq == 0, "R10 irq cleared", irq, 0);

        // R4 memory to peripheral, 3 words, with R9 writes while busy
        wr(2'd0, 32'h40); wr(2'd1, 32'h3); wr(2'd2, 32'h1);
        dlat = 3; mlat = 0;
        base_idx = got_idx;
        wr(2'd3, 32'h1);
        wr(2'd0, 32'h99);
        wr(2'd2, 32'h2);
        wr(2'd3, 32'h1);
        wait_idle();
        for (int i = 0; i < 3; i++)
            chk(dev_got[(base_idx + i) % 64] == init_word(8'h40 + i), "R4 device word",
                dev_got[(base_idx + i) % 64], init_word(8'h40 + i));
        rd_chk(2'd0, 32'h43, "R9 addr not overwritten while busy");
        rd_chk(2'd2, 32'h1, "R9 ctrl not overwritten while busy");
        rd_chk(2'd3, 32'h2, "R6 done after second run");
        chk(irq == 0, "R10 irq off with enable low", irq, 0);
        wr(2'd3, 32'h2);

        // R8 zero length launch
        wr(2'd3, 32'h1);
        rd_chk(2'd3, 32'h4, "R8 error on zero count");
        chk(!dev_req && !mem_req, "R8 no request", {dev_req, mem_req}, 0);
        wr(2'd3, 32'h2);
        rd_chk(2'd3, 32'h0, "R7 error cleared");

        // single word boundary, direction 0
        wr(2'd0, 32'hFF); wr(2'd1, 32'h1); wr(2'd2, 32'h0);
        dlat = 1; mlat = 1;
        base_idx = dev_idx;
        wr(2'd3, 32'h1);
        wait_idle();
        chk(mem[8'hFF] == src_word(base_idx), "R3 single word", mem[8'hFF], src_word(base_idx));
        rd_chk(2'd0, 32'h100, "R5 single word addr");
        rd_chk(2'd3, 32'h2, "R6 single word done");

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule